// File: doc/BRIEF.md
# Chaos-Whitened Shift-Register Bit Generator

This block emits one pseudo-random bit per enabled clock. Two sources run side by side. The first is a 16-bit linear feedback shift register whose feedback can be arranged in either of two ways. In the external arrangement, the XOR of the tap bits enters at the low end. In the internal arrangement, the bit leaving the top is folded into the tap positions as the register shifts. The second source is a fixed-point iterator of the logistic map, x' = r * x * (1 - x). The serial output is the XOR of the register's top bit and the top bit of the map state.

Software or a controller first pulses `load_i` with a register seed, an initial map state, a map parameter and the arrangement to use. It then holds `enable_i` high for as many bits as it needs. `valid_o` marks the point from which `bit_o` carries generated data.

Top module: `chaos_lfsr_gen`

## Requirements
- R1: After reset, bit_o and valid_o are 0. The internal state is then register = 16'h0001, map state = 16'h9E37, parameter = 4.0 and the external arrangement, so enabling without a load yields the stream of that state.
- R2: A clock edge with load_i high captures seed_i, map_x_i, map_r_i and mode_i and clears valid_o. Load wins over enable_i in the same cycle.
- R3: valid_o rises at the first edge with enable_i high and load_i low after a load (or reset). It then stays high until the next load.
- R4: An edge with enable_i low and load_i low leaves bit_o, valid_o and all generator state unchanged, so the stream resumes where it paused.
- R5: With mode_i = 0 at load (external arrangement, register s[15:0]), each enabled edge sets s to {s[14:0], s[15]^s[14]^s[12]^s[3]}. This is the tap set 16, 15, 13, 4.
- R6: With mode_i = 1 at load (internal arrangement), each enabled edge sets s to {s[14:0],1'b0} XOR (s[15] ? 16'hA011 : 0).
- R7: The map state x is an unsigned Q0.16 fraction and r is unsigned Q3.14 (17 bits). One update forms p = floor(x*(65536-x)/65536), then n = floor(r*p/16384). An n of 65536 or more saturates to 16'hFFFF.
- R8: A map state of 16'h0000 or 16'hFFFF, whether loaded or produced by an update, is replaced by 16'h9E37.
- R9: A loaded map_r_i above 17'h10000 (4.0) is stored as 17'h10000. A value below 17'h04000 (1.0) is stored as 17'h04000.
- R10: A loaded seed of zero is stored as 16'h0001.
- R11: At every enabled edge, bit_o takes s[15] XOR x[15] of the states held before that edge, while both states advance.
- R12: mode_i has no effect except at a load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture seed, map state, parameter and mode |
| mode_i | input | 1 | 0 external feedback, 1 internal feedback |
| seed_i | input | 16 | Shift-register seed |
| map_x_i | input | 16 | Initial map state, Q0.16 |
| map_r_i | input | 17 | Map parameter, Q3.14 |
| enable_i | input | 1 | Produce one bit this cycle |
| bit_o | output | 1 | Generated bit |
| valid_o | output | 1 | bit_o holds generated data |

## Verification
The assertions take for granted that load_i and enable_i are clean synchronous levels. Values outside the legal ranges on seed_i, map_x_i and map_r_i are not assumed away: the invariants on stored state (nonzero register, map state never 0 or all ones, parameter within 1.0 to 4.0) must hold for any loaded value. The stimulus changes every input only on the falling clock edge. It deliberately drives zero seeds, zero and all-ones map states, and parameters beyond both ends of the range, so the clamping and rescue paths are exercised rather than avoided.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
  typedef enum logic {
    MODE_EXT = 1'b0,
    MODE_INT = 1'b1
  } fb_mode_e;

  localparam int unsigned LFSR_W  = 16;
  localparam int unsigned X_W     = 16;
  localparam int unsigned R_FRAC  = 14;
  localparam int unsigned R_W     = R_FRAC + 3;
  localparam logic [LFSR_W-1:0] TAPS_EXT   = 16'hD008;
  localparam logic [X_W-1:0]    X_RESCUE   = 16'h9E37;
endpackage

// File: rtl/cmg_lfsr.sv
module cmg_lfsr
  import cmg_pkg::*;
#(
  parameter int unsigned         W    = LFSR_W,
  parameter logic [W-1:0]        TAPS = TAPS_EXT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  fb_mode_e     mode_i,
  input  logic [W-1:0] seed_i,
  output logic         out_o,
  output logic [W-1:0] state_o
);
  // internal form mask: taps rotated by one (x^W term maps to bit 0)
  localparam logic [W-1:0] GAL_MASK = {TAPS[W-2:0], TAPS[W-1]};
  localparam logic [W-1:0] SEED_ONE = W'(1);

  logic [W-1:0] s_q;
  fb_mode_e     mode_q;
  logic [W-1:0] ext_next;
  logic [W-1:0] int_next;
  logic         ext_fb;

  assign ext_fb = ^(s_q & TAPS);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lo
        assign ext_next[i] = ext_fb;
        assign int_next[i] = GAL_MASK[i] & s_q[W-1];
      end else begin : g_hi
        assign ext_next[i] = s_q[i-1];
        assign int_next[i] = s_q[i-1] ^ (GAL_MASK[i] & s_q[W-1]);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= SEED_ONE;
      mode_q <= MODE_EXT;
    end else if (load_i) begin
      s_q    <= (seed_i == '0) ? SEED_ONE : seed_i;
      mode_q <= mode_i;
    end else if (step_i) begin
      s_q    <= (mode_q == MODE_INT) ? int_next : ext_next;
    end
  end

  assign out_o   = s_q[W-1];
  assign state_o = s_q;
endmodule

// File: rtl/cmg_logistic.sv
module cmg_logistic
  import cmg_pkg::*;
#(
  parameter int unsigned       XW     = X_W,
  parameter int unsigned       RF     = R_FRAC,
  parameter logic [XW-1:0]     RESCUE = X_RESCUE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [XW-1:0] x_i,
  input  logic [RF+2:0] r_i,
  output logic          msb_o,
  output logic [XW-1:0] x_o,
  output logic [RF+2:0] r_o
);
  localparam int unsigned RW    = RF + 3;
  localparam int unsigned P1W   = 2 * XW + 1;
  localparam int unsigned P2W   = RW + XW;
  localparam logic [RW-1:0] R_LO = RW'(1) << RF;
  localparam logic [RW-1:0] R_HI = RW'(4) << RF;
  localparam logic [XW:0]   X_ONE = (XW+1)'(1) << XW;

  logic [XW-1:0]  x_q;
  logic [RW-1:0]  r_q;
  logic [XW:0]    one_minus;
  logic [P1W-1:0] prod1;
  logic [XW-1:0]  xx;
  logic [P2W-1:0] prod2;
  logic [P2W-1:0] scaled;
  logic [XW-1:0]  sat;
  logic [XW-1:0]  x_next;
  logic [XW-1:0]  x_load;
  logic [RW-1:0]  r_load;

  function automatic logic [XW-1:0] guard(input logic [XW-1:0] v);
    return ((v == '0) || (v == '1)) ? RESCUE : v;
  endfunction

  assign one_minus = X_ONE - {1'b0, x_q};
  assign prod1     = P1W'(x_q) * P1W'(one_minus);
  assign xx        = prod1[2*XW-1:XW];
  assign prod2     = P2W'(r_q) * P2W'(xx);
  assign scaled    = prod2 >> RF;
  assign sat       = (scaled >= P2W'(X_ONE)) ? '1 : scaled[XW-1:0];
  assign x_next    = guard(sat);

  assign x_load = guard(x_i);
  assign r_load = (r_i > R_HI) ? R_HI : ((r_i < R_LO) ? R_LO : r_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= RESCUE;
      r_q <= R_HI;
    end else if (load_i) begin
      x_q <= x_load;
      r_q <= r_load;
    end else if (step_i) begin
      x_q <= x_next;
    end
  end

  assign msb_o = x_q[XW-1];
  assign x_o   = x_q;
  assign r_o   = r_q;
endmodule

// File: rtl/cmg_mix.sv
module cmg_mix (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  logic lin_i,
  input  logic chaos_i,
  output logic bit_o,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b0;
    end else if (step_i) begin
      bit_o   <= lin_i ^ chaos_i;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/chaos_lfsr_gen.sv
module chaos_lfsr_gen
  import cmg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              mode_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [X_W-1:0]    map_x_i,
  input  logic [R_W-1:0]    map_r_i,
  input  logic              enable_i,
  output logic              bit_o,
  output logic              valid_o
);
  logic              step;
  logic              lin_bit;
  logic              chaos_bit;
  logic [LFSR_W-1:0] lfsr_state;
  logic [X_W-1:0]    map_x;
  logic [R_W-1:0]    map_r;
  fb_mode_e          mode_sel;

  assign step     = enable_i & ~load_i;
  assign mode_sel = fb_mode_e'(mode_i);

  cmg_lfsr #(.W(LFSR_W), .TAPS(TAPS_EXT)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .step_i  (step),
    .mode_i  (mode_sel),
    .seed_i  (seed_i),
    .out_o   (lin_bit),
    .state_o (lfsr_state)
  );

  cmg_logistic #(.XW(X_W), .RF(R_FRAC), .RESCUE(X_RESCUE)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .step_i (step),
    .x_i    (map_x_i),
    .r_i    (map_r_i),
    .msb_o  (chaos_bit),
    .x_o    (map_x),
    .r_o    (map_r)
  );

  cmg_mix u_mix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .step_i  (step),
    .lin_i   (lin_bit),
    .chaos_i (chaos_bit),
    .bit_o   (bit_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/chaos_lfsr_gen_chk.sv
module chaos_lfsr_gen_chk
  import cmg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              enable_i,
  input logic              bit_o,
  input logic              valid_o,
  input logic [LFSR_W-1:0] lfsr_state,
  input logic [X_W-1:0]    map_x,
  input logic [R_W-1:0]    map_r
);
  localparam logic [R_W-1:0] R_LO = R_W'(1) << R_FRAC;
  localparam logic [R_W-1:0] R_HI = R_W'(4) << R_FRAC;

  assert_load_clears_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);

  assert_valid_after_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !load_i) |=> valid_o);

  assert_valid_falls_only_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(load_i));

  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !load_i) |=> ($stable(bit_o) && $stable(valid_o) &&
                                $stable(lfsr_state) && $stable(map_x)));

  assert_map_never_stuck_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_x != '0) && (map_x != '1));

  assert_r_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_r >= R_LO) && (map_r <= R_HI));

  assert_lfsr_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0);

  assert_r_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(map_r));
endmodule

bind chaos_lfsr_gen chaos_lfsr_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .enable_i   (enable_i),
  .bit_o      (bit_o),
  .valid_o    (valid_o),
  .lfsr_state (lfsr_state),
  .map_x      (map_x),
  .map_r      (map_r)
);

// File: tb/chaos_lfsr_gen_tb_top.sv
module chaos_lfsr_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [15:0] map_x_i = '0;
  logic [16:0] map_r_i = '0;
  logic        enable_i = 1'b0;
  logic        bit_o;
  logic        valid_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done = 1'b0;

  logic [15:0] m_s;
  logic [15:0] m_x;
  logic [16:0] m_r;
  logic        m_mode;

  always #10 clk_i = ~clk_i;

  chaos_lfsr_gen dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .mode_i   (mode_i),
    .seed_i   (seed_i),
    .map_x_i  (map_x_i),
    .map_r_i  (map_r_i),
    .enable_i (enable_i),
    .bit_o    (bit_o),
    .valid_o  (valid_o)
  );

  // {mode, seed, x, r}
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'hACE1, 16'h4000, 17'h0F5C3},
    {1'b1, 16'hACE1, 16'h4000, 17'h0F5C3},
    {1'b0, 16'h1234, 16'h1111, 17'h10000},
    {1'b1, 16'hFFFF, 16'hC350, 17'h0E666},
    {1'b0, 16'h8001, 16'h0101, 17'h0CCCD},
    {1'b1, 16'h5555, 16'h7FFF, 17'h08000},
    {1'b0, 16'h0F0F, 16'h2AAA, 17'h0FFFF},
    {1'b1, 16'h00FF, 16'hFEDC, 17'h0B000}
  };

  function automatic logic [15:0] ref_guard(input logic [15:0] v);
    return (v == 16'h0000 || v == 16'hFFFF) ? 16'h9E37 : v;
  endfunction

  function automatic logic [15:0] ref_lfsr(input logic md, input logic [15:0] s);
    if (!md) return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    return {s[14:0], 1'b0} ^ (s[15] ? 16'hA011 : 16'h0000);
  endfunction

  function automatic logic [15:0] ref_map(input logic [16:0] r, input logic [15:0] x);
    longint unsigned om, p1, p2;
    om = 64'd65536 - 64'(x);
    p1 = (64'(x) * om) >> 16;
    p2 = (64'(r) * p1) >> 14;
    if (p2 > 64'd65535) p2 = 64'd65535;
    return ref_guard(p2[15:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic md, input logic [15:0] sd, input logic [15:0] x,
                         input logic [16:0] r, input logic en, input string req);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = md; seed_i = sd; map_x_i = x; map_r_i = r; enable_i = en;
    @(negedge clk_i);
    load_i = 1'b0; enable_i = 1'b0;
    m_mode = md;
    m_s = (sd == 16'h0) ? 16'h0001 : sd;
    m_x = ref_guard(x);
    m_r = (r > 17'h10000) ? 17'h10000 : ((r < 17'h04000) ? 17'h04000 : r);
    check(req, {31'b0, valid_o}, 32'd0);
  endtask

  task automatic step(input string req);
    logic e;
    e = m_s[15] ^ m_x[15];
    enable_i = 1'b1;
    @(negedge clk_i);
    check(req, {31'b0, bit_o}, {31'b0, e});
    check("R3", {31'b0, valid_o}, 32'd1);
    m_s = ref_lfsr(m_mode, m_s);
    m_x = ref_map(m_r, m_x);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
    enable_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic held;
    // R1: reset values
    repeat (3) @(negedge clk_i);
    check("R1", {30'b0, bit_o, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {30'b0, bit_o, valid_o}, 32'd0);
    m_s = 16'h0001; m_x = 16'h9E37; m_r = 17'h10000; m_mode = 1'b0;
    run(20, "R1");

    // table walk: R5/R6/R7/R11 under several seeds and parameters
    for (int v = 0; v < NV; v++) begin
      do_load(VEC[v][49], VEC[v][48:33], VEC[v][32:17], VEC[v][16:0], 1'b0, "R2");
      run(40, VEC[v][49] ? "R6_R11" : "R5_R11");
    end

    // R2: load wins over a simultaneous enable
    do_load(1'b0, 16'hBEEF, 16'h3333, 17'h0F000, 1'b1, "R2");
    run(10, "R2");

    // R4: pause leaves output and state frozen
    do_load(1'b1, 16'h2468, 16'h6000, 17'h0F800, 1'b0, "R2");
    run(7, "R4");
    held = bit_o;
    repeat (5) @(negedge clk_i);
    check("R4", {31'b0, bit_o}, {31'b0, held});
    check("R4", {31'b0, valid_o}, 32'd1);
    run(15, "R4");

    // R12: mode_i toggling outside load is ignored
    do_load(1'b0, 16'h9999, 16'h5151, 17'h0E000, 1'b0, "R2");
    for (int i = 0; i < 20; i++) begin
      mode_i = i[0];
      step("R12");
    end
    enable_i = 1'b0;

    // R8: loaded zero / all-ones, computed saturation (4.0, 0.5), computed zero (r=1, x=1/65536)
    do_load(1'b0, 16'h7777, 16'h0000, 17'h0C000, 1'b0, "R2");
    run(12, "R8");
    do_load(1'b1, 16'h7777, 16'hFFFF, 17'h0C000, 1'b0, "R2");
    run(12, "R8");
    do_load(1'b0, 16'h0001, 16'h8000, 17'h10000, 1'b0, "R2");
    run(12, "R7_R8");
    do_load(1'b1, 16'h4321, 16'h0001, 17'h04000, 1'b0, "R2");
    run(12, "R8");

    // R9: parameter clamps at both ends
    do_load(1'b0, 16'hA5A5, 16'h3210, 17'h1FFFF, 1'b0, "R2");
    run(30, "R9");
    do_load(1'b1, 16'hA5A5, 16'h3210, 17'h00001, 1'b0, "R2");
    run(30, "R9");

    // R10: zero seed becomes one, both forms
    do_load(1'b0, 16'h0000, 16'h4567, 17'h0F000, 1'b0, "R2");
    run(30, "R10");
    do_load(1'b1, 16'h0000, 16'h4567, 17'h0F000, 1'b0, "R2");
    run(30, "R10");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule